// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Counter with One-Hot Phase Decode

This block is a shift-register counter of `N` stages whose last stage is fed back inverted into the first. The counter therefore walks through 2N states and divides the clock by 2N. Every stage output is a square wave with 50% duty cycle. Each stage lags its neighbour by one clock, so the raw stages give N overlapping phases. A decoder turns the register into 2N one-hot lines, one line per state, and each line comes from a single two-input AND of two adjacent bits in the ring.

Of the 2^N patterns that the register can hold, only 2N belong to the counting cycle. The feedback into the third stage carries a small correction. Whenever the first three stages read 0,1,0, a 0 is shifted into the third stage instead of the 1 that a plain shift would give. Every stray pattern, however it arose, is therefore driven back into the legal cycle within a bounded number of enabled clocks, with no reset needed.

A load port writes any pattern straight into the register. It is meant for bring-up and test, so that stray patterns can be forced in on purpose.

Control is a four-way choice made each clock, in priority order:

- **CLEAR** when `rst` is high.
- **LOAD** when `load_en` is high.
- **SHIFT** when `en` is high.
- **HOLD** otherwise.

Each choice takes the register to a new value:

- CLEAR goes to all zeros.
- LOAD goes to `load_val`.
- SHIFT goes to the corrected twisted shift.
- HOLD keeps the register unchanged.

Top module: `twisted_ring_counter`

## Requirements
- R1: While `rst` is sampled high at a clock edge, `stage_q` becomes all zeros after that edge and `dec_q` shows only bit 0 high; `rst` takes priority over `load_en` and `en`.
- R2: On an edge with `en` high, `load_en` and `rst` low, and a legal state, `stage_q[0]` takes the inverse of `stage_q[N-1]` and `stage_q[k+1]` takes `stage_q[k]`. For N = 4, writing `stage_q[0]` first, the states from clear are 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001, and the sequence then repeats with period 2N.
- R3: Over one full cycle of 2N enabled clocks, each stage is high for exactly N clocks, and stage k+1 shows the value that stage k held one clock earlier.
- R4: In the legal state reached j enabled clocks after a clear (0 <= j < 2N), exactly bit j of `dec_q` is high. State j has its low j bits set for j <= N, and bits j-N through N-1 set for j > N.
- R5: With `en`, `load_en` and `rst` all low, `stage_q` and `dec_q` keep their values across clock edges.
- R6: On an enabled shift in which `stage_q[0]` = 0, `stage_q[1]` = 1 and `stage_q[2]` = 0, the next `stage_q[2]` is 0. For N = 4, the pattern with only `stage_q[1]` set goes to the pattern with only `stage_q[0]` set.
- R7: With `load_en` high and `rst` low, `stage_q` equals `load_val` after the edge, whatever the value of `en`.
- R8: From any of the 2^N register patterns, a legal state is reached within 2N enabled clocks. From that point the counter follows the R2 sequence and R4 decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous clear to the all-zero state |
| en | input | 1 | Clock enable for the shift |
| load_en | input | 1 | Test load strobe, writes `load_val` into the register |
| load_val | input | N | Pattern written by `load_en`, bit 0 is the first stage |
| stage_q | output | N | Raw stage outputs, bit 0 is the first stage |
| dec_q | output | 2N | One-hot state decode, bit j marks state j |

## Verification
A run of two full cycles from clear compares the register and the decode with the state computed from the step count. This separates a wrong feedback polarity or shift direction from a wrong decode mapping. The same run counts the ones on each stage, which exposes duty-cycle or lag faults that a single snapshot would miss. A preload of the single stray pattern 0,1,0 checks the correction bit by bit. A sweep that loads all 2^N patterns measures the number of clocks to recovery, then checks the decode and the next step; this tells a missing or misplaced correction apart from a slow one. Separate hold, load-with-enable-low and clear-over-load cases probe the control priority.

// File: rtl/twr_pkg.sv
package twr_pkg;

    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_SHIFT = 2'd2,
        ACT_HOLD  = 2'd3
    } twr_act_e;

    // A ring pattern is in the counting cycle when its bits, read in stage
    // order, change value at most once.
    function automatic logic ring_legal(input logic [31:0] v, input int n);
        int edges;
        edges = 0;
        for (int k = 0; k < 31; k++) begin
            if (k < n - 1 && v[k] != v[k+1]) begin
                edges++;
            end
        end
        return (edges <= 1);
    endfunction

endpackage

// File: rtl/twr_stage_reg.sv
module twr_stage_reg
    import twr_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         load_en,
    input  logic [N-1:0] load_val,
    output logic [N-1:0] q
);

    twr_act_e     act;
    logic [N-1:0] shift_nxt;
    logic [N-1:0] q_nxt;

    // Control choice, highest priority first.
    always_comb begin
        if (rst)          act = ACT_CLEAR;
        else if (load_en) act = ACT_LOAD;
        else if (en)      act = ACT_SHIFT;
        else              act = ACT_HOLD;
    end

    // Twisted shift; stage 2 carries the stray-pattern correction.
    always_comb begin
        shift_nxt[0] = ~q[N-1];
        for (int k = 1; k < N; k++) begin
            shift_nxt[k] = q[k-1];
        end
        shift_nxt[2] = q[1] & (q[0] | q[2]);
    end

    always_comb begin
        unique case (act)
            ACT_CLEAR: q_nxt = '0;
            ACT_LOAD:  q_nxt = load_val;
            ACT_SHIFT: q_nxt = shift_nxt;
            ACT_HOLD:  q_nxt = q;
            default:   q_nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        q <= q_nxt;
    end

    logic legal_now;
    assign legal_now = ring_legal(32'(q), N);

    a_r1_clear: assert property (@(posedge clk)
        rst |=> (q == '0));

    a_r7_load: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (q == $past(load_val)));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !load_en) |=> $stable(q));

    a_r2_legal_step: assert property (@(posedge clk) disable iff (rst)
        (en && !load_en && legal_now)
        |=> (q == {$past(q[N-2:0]), ~$past(q[N-1])}));

    a_r6_fix: assert property (@(posedge clk) disable iff (rst)
        (en && !load_en && q[2:0] == 3'b010) |=> (q[2] == 1'b0));

endmodule

// File: rtl/twr_decoder.sv
module twr_decoder #(
    parameter int N = 4,
    localparam int S = 2 * N
) (
    input  logic [N-1:0] q,
    output logic [S-1:0] dec
);

    // Every line is a two-input AND of ring-adjacent stages.
    assign dec[0] = ~q[0] & ~q[N-1];
    assign dec[N] =  q[0] &  q[N-1];

    for (genvar j = 1; j < N; j++) begin : g_edge
        assign dec[j]     =  q[j-1] & ~q[j];
        assign dec[N + j] = ~q[j-1] &  q[j];
    end

endmodule

// File: rtl/twisted_ring_counter.sv
module twisted_ring_counter
    import twr_pkg::*;
#(
    parameter int N = 4,
    localparam int S  = 2 * N,
    localparam int CW = $clog2(S + 2)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         load_en,
    input  logic [N-1:0] load_val,
    output logic [N-1:0] stage_q,
    output logic [S-1:0] dec_q
);

    if (N < 3 || N > 32) begin : g_bad_n
        $error("twisted_ring_counter: N must lie in 3..32");
    end

    twr_stage_reg #(.N(N)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .load_en  (load_en),
        .load_val (load_val),
        .q        (stage_q)
    );

    twr_decoder #(.N(N)) u_dec (
        .q   (stage_q),
        .dec (dec_q)
    );

    // Length of the current run of stray patterns, in enabled clocks.
    logic          legal_now;
    logic [CW-1:0] stray_run;

    assign legal_now = ring_legal(32'(stage_q), N);

    always_ff @(posedge clk) begin
        if (rst || load_en) begin
            stray_run <= '0;
        end else if (en) begin
            if (legal_now)                      stray_run <= '0;
            else if (stray_run != CW'(S + 1))   stray_run <= stray_run + 1'b1;
        end
    end

    a_r8_recover: assert property (@(posedge clk) disable iff (rst || load_en)
        $past(!rst && !load_en) |-> (stray_run < CW'(S)));

    a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
        legal_now |-> $onehot(dec_q));

endmodule

// File: tb/twisted_ring_counter_tb_top.sv
module twisted_ring_counter_tb_top;
    localparam int N = 4;
    localparam int S = 2 * N;

    logic         clk = 1'b0;
    logic         rst, en, load_en;
    logic [N-1:0] load_val;
    logic [N-1:0] stage_q;
    logic [S-1:0] dec_q;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    twisted_ring_counter #(.N(N)) dut_i (
        .clk(clk), .rst(rst), .en(en), .load_en(load_en),
        .load_val(load_val), .stage_q(stage_q), .dec_q(dec_q)
    );

    function automatic logic [N-1:0] pat_of(input int j);
        int m;
        m = j % S;
        if (m <= N) return N'((1 << m) - 1);
        return N'(((1 << N) - 1) & ~((1 << (m - N)) - 1));
    endfunction

    function automatic int idx_of(input logic [N-1:0] v);
        for (int j = 0; j < S; j++) begin
            if (pat_of(j) == v) return j;
        end
        return -1;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ones [N];
        logic [N-1:0] prev_s, hold_s;
        logic [S-1:0] hold_d;
        int n, j0;

        rst = 1'b1; en = 1'b0; load_en = 1'b0; load_val = '0;
        step(); step();
        check(stage_q == '0, "R1 clear", 64'(stage_q), 0);
        check(dec_q == S'(1), "R1 decode", 64'(dec_q), 1);

        // R1: clear wins over a simultaneous load.
        rst = 1'b0; load_en = 1'b1; load_val = pat_of(3);
        step();
        rst = 1'b1; load_val = pat_of(5);
        step();
        check(stage_q == '0, "R1 clear over load", 64'(stage_q), 0);
        rst = 1'b0; load_en = 1'b0;

        // R2, R3, R4: two full cycles from clear.
        for (int k = 0; k < N; k++) ones[k] = 0;
        en = 1'b1;
        prev_s = stage_q;
        for (int j = 1; j <= 2 * S; j++) begin
            step();
            check(stage_q == pat_of(j), "R2 sequence", 64'(stage_q), 64'(pat_of(j)));
            check(dec_q == S'(1 << (j % S)), "R4 decode", 64'(dec_q), 64'(1 << (j % S)));
            check(stage_q[N-1:1] == prev_s[N-2:0], "R3 lag",
                  64'(stage_q[N-1:1]), 64'(prev_s[N-2:0]));
            if (j <= S) begin
                for (int k = 0; k < N; k++) ones[k] += int'(stage_q[k]);
            end
            prev_s = stage_q;
        end
        for (int k = 0; k < N; k++) begin
            check(ones[k] == N, "R3 duty", 64'(ones[k]), 64'(N));
        end

        // R5: hold with enable low.
        en = 1'b0;
        step();
        hold_s = stage_q; hold_d = dec_q;
        for (int k = 0; k < 3; k++) begin
            step();
            check(stage_q == hold_s, "R5 hold stage", 64'(stage_q), 64'(hold_s));
            check(dec_q == hold_d, "R5 hold decode", 64'(dec_q), 64'(hold_d));
        end

        // R7: load while enable is low.
        load_en = 1'b1; load_val = pat_of(3);
        step();
        load_en = 1'b0;
        check(stage_q == pat_of(3), "R7 load", 64'(stage_q), 64'(pat_of(3)));
        step();
        check(stage_q == pat_of(3), "R7 load then hold", 64'(stage_q), 64'(pat_of(3)));

        // R6: stray 0,1,0 in the first three stages.
        load_en = 1'b1; load_val = N'(2);
        step();
        load_en = 1'b0; en = 1'b1;
        step();
        check(stage_q[2] == 1'b0, "R6 third stage", 64'(stage_q[2]), 0);
        check(stage_q == N'(1), "R6 next pattern", 64'(stage_q), 1);

        // R8: every pattern recovers within 2N clocks.
        for (int p = 0; p < (1 << N); p++) begin
            load_en = 1'b1; load_val = N'(p);
            step();
            load_en = 1'b0;
            check(stage_q == N'(p), "R7 sweep load", 64'(stage_q), 64'(p));
            n = 0;
            while (idx_of(stage_q) < 0 && n <= S) begin
                step();
                n++;
            end
            check(n <= S, "R8 recovery clocks", 64'(n), 64'(S));
            j0 = idx_of(stage_q);
            if (j0 >= 0) begin
                check(dec_q == S'(1 << j0), "R8 decode after recovery",
                      64'(dec_q), 64'(1 << j0));
                step();
                check(stage_q == pat_of(j0 + 1), "R8 step after recovery",
                      64'(stage_q), 64'(pat_of(j0 + 1)));
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule